// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat synchronous memory burst. A burst opens when one of two active-low address strobes captures a start address together with three chip-enable inputs. After that, an active-low step input moves the burst on by one beat per clock. The upper address bits never change during a burst. Only the two low bits follow the beat order. A static order input selects that order: either the start bits XORed with the beat number, or the start bits plus the beat number, wrapping within four words.

The two strobes follow different rules. The processor strobe is accepted only while the primary chip enable is active. The controller strobe is accepted in every case. When both are accepted in the same cycle, the processor strobe wins. The design reports which strobe opened the burst and whether the captured chip enables selected the device. All pins are plain control or status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, addr_out is 0, beat_idx is 0, burst_sel is 0 and src_proc is 0.
- R2: At a rising edge where proc_strobe_n is 0 and sel_lo_n is 0, the block captures addr_in. Beat_idx becomes 0 and src_proc becomes 1.
- R3: At a rising edge where ctrl_strobe_n is 0 and the processor strobe is not accepted (proc_strobe_n is 1 or sel_lo_n is 1), the block captures addr_in. Beat_idx becomes 0 and src_proc becomes 0.
- R4: When both strobes are low and sel_lo_n is 0, the processor strobe takes priority, so src_proc becomes 1.
- R5: A processor strobe with sel_lo_n at 1, and with ctrl_strobe_n at 1, is ignored. All outputs keep their values.
- R6: Every accepted strobe records burst_sel = (sel_lo_n==0 && sel_hi==1 && sel_exp_n==0), using the values present at that edge.
- R7: With no strobe accepted, step_n at 0 and burst_sel at 1, beat_idx advances by one modulo 4 at the edge.
- R8: With no strobe accepted and either step_n at 1 or burst_sel at 0, beat_idx and addr_out hold (suspend).
- R9: addr_out[16:2] keeps its loaded value until the next accepted strobe.
- R10: When mode_linear is 0, addr_out[1:0] equals the start bits XOR beat_idx.
- R11: When mode_linear is 1, addr_out[1:0] equals (start bits + beat_idx) modulo 4.
- R12: mode_linear is not registered. A change in it alters addr_out[1:0] at once, with no clock edge.
- R13: After four steps, beat_idx is 0 again and addr_out equals the start address. There is no carry into bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Beat advance, active low |
| sel_lo_n | input | 1 | Primary chip enable, active low |
| sel_hi | input | 1 | Chip enable, active high |
| sel_exp_n | input | 1 | Depth-expansion chip enable, active low |
| mode_linear | input | 1 | Beat order: 0 XOR, 1 wrapping increment |
| addr_in | input | 17 | Start word address |
| addr_out | output | 17 | Current beat address |
| beat_idx | output | 2 | Beat number within the burst |
| burst_sel | output | 1 | Captured chip enables select the device |
| src_proc | output | 1 | The processor strobe opened the burst |

## Verification
A corrupted start register or beat counter shows on addr_out in the first cycle after the edge that should have loaded or stepped it. A carry into the upper bits shows four beats after the load, when the address should return to the start. A registered order input would show as a delay of one cycle after a mode change. A wrong strobe priority or a broken enable gate shows at the next edge on src_proc, on burst_sel, or on an address that should have stayed put.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_INC = 1'b1
  } beat_order_e;

  typedef struct packed {
    logic lo_n;
    logic hi;
    logic exp_n;
  } chip_en_t;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic sel_lo_n,
  output logic load,
  output logic from_proc
);
  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    proc_ok   = !proc_strobe_n && !sel_lo_n;
    ctrl_ok   = !ctrl_strobe_n;
    load      = proc_ok || ctrl_ok;
    from_proc = proc_ok;
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              from_proc,
  input  logic [ADDR_W-1:0] addr_in,
  input  chip_en_t          en_in,
  output logic [ADDR_W-1:0] start_addr,
  output logic              selected,
  output logic              src_proc
);
  chip_en_t en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      en_q       <= '{lo_n: 1'b1, hi: 1'b0, exp_n: 1'b1};
      src_proc   <= 1'b0;
    end else if (load) begin
      start_addr <= addr_in;
      en_q       <= en_in;
      src_proc   <= from_proc;
    end
  end

  always_comb selected = !en_q.lo_n && en_q.hi && !en_q.exp_n;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat <= '0;
    else if (load)    beat <= '0;
    else if (advance) beat <= beat + 1'b1;
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  beat_order_e       order,
  output logic [BEAT_W-1:0] lo_out
);
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] inc_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign inc_lo = start_lo + beat;

  always_comb lo_out = (order == ORDER_INC) ? inc_lo : xor_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              step_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              sel_exp_n,
  input  logic              mode_linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              burst_sel,
  output logic              src_proc
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              from_proc;
  logic [ADDR_W-1:0] start_addr;
  logic [BEAT_W-1:0] lo_bits;
  chip_en_t          en_now;
  beat_order_e       order;

  always_comb begin
    en_now = '{lo_n: sel_lo_n, hi: sel_hi, exp_n: sel_exp_n};
    order  = beat_order_e'(mode_linear);
  end

  burst_strobe_decode u_dec (
    .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n),
    .sel_lo_n     (sel_lo_n),
    .load         (load),
    .from_proc    (from_proc)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .from_proc (from_proc),
    .addr_in   (addr_in),
    .en_in     (en_now),
    .start_addr(start_addr),
    .selected  (burst_sel),
    .src_proc  (src_proc)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .advance(!step_n && burst_sel),
    .beat   (beat_idx)
  );

  burst_addr_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo(start_addr[BEAT_W-1:0]),
    .beat    (beat_idx),
    .order   (order),
    .lo_out  (lo_bits)
  );

  assign addr_out = {start_addr[ADDR_W-1 -: HI_W], lo_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              step_n,
  input logic              sel_lo_n,
  input logic              sel_hi,
  input logic              sel_exp_n,
  input logic              mode_linear,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat_idx,
  input logic              burst_sel,
  input logic              src_proc
);
  logic p_ok, any_ok;
  assign p_ok   = !proc_strobe_n && !sel_lo_n;
  assign any_ok = p_ok || !ctrl_strobe_n;

  a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
    p_ok |=> src_proc && beat_idx == '0 &&
             addr_out[ADDR_W-1:BEAT_W] == $past(addr_in[ADDR_W-1:BEAT_W]));

  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe_n && !p_ok) |=> !src_proc && beat_idx == '0);

  a_r6_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    any_ok |=> burst_sel == $past(!sel_lo_n && sel_hi && !sel_exp_n));

  a_r5_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ok |=> $stable(src_proc) && $stable(burst_sel) &&
                $stable(addr_out[ADDR_W-1:BEAT_W]));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ok && !step_n && burst_sel) |=> beat_idx == $past(beat_idx) + 1'b1);

  a_r8_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ok && (step_n || !burst_sel)) |=> $stable(beat_idx));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
  .ctrl_strobe_n(ctrl_strobe_n), .step_n(step_n), .sel_lo_n(sel_lo_n),
  .sel_hi(sel_hi), .sel_exp_n(sel_exp_n), .mode_linear(mode_linear),
  .addr_in(addr_in), .addr_out(addr_out), .beat_idx(beat_idx),
  .burst_sel(burst_sel), .src_proc(src_proc)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        proc_strobe_n, ctrl_strobe_n, step_n;
  logic        sel_lo_n, sel_hi, sel_exp_n, mode_linear;
  logic [16:0] addr_in;
  logic [16:0] addr_out;
  logic [1:0]  beat_idx;
  logic        burst_sel, src_proc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .step_n(step_n), .sel_lo_n(sel_lo_n),
    .sel_hi(sel_hi), .sel_exp_n(sel_exp_n), .mode_linear(mode_linear),
    .addr_in(addr_in), .addr_out(addr_out), .beat_idx(beat_idx),
    .burst_sel(burst_sel), .src_proc(src_proc)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; step_n = 1;
    sel_lo_n = 0; sel_hi = 1; sel_exp_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k, input logic lin);
    return lin ? 2'(s + k) : (s ^ k);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(); mode_linear = 0; addr_in = 17'h1ABCD; rst_n = 0;
    tick(); tick();
    // R1 reset state
    check("R1 addr", addr_out, 0); check("R1 beat", beat_idx, 0);
    check("R1 sel", burst_sel, 0); check("R1 src", src_proc, 0);
    rst_n = 1;

    // Sweep: order x strobe x start low bits, five steps each (R2 R3 R7 R9 R10 R11 R13)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [16:0] st;
          st = {15'(15'h2D31 ^ 15'(lo * 977 + m * 31 + s * 5)), 2'(lo)};
          mode_linear = m[0];
          idle(); addr_in = st;
          if (s == 1) proc_strobe_n = 0; else ctrl_strobe_n = 0;
          tick();
          check(s ? "R2 load addr" : "R3 load addr", addr_out, st);
          check(s ? "R2 src" : "R3 src", src_proc, s);
          check("R6 sel", burst_sel, 1);
          idle(); addr_in = ~st; step_n = 0;
          for (int k = 1; k <= 5; k++) begin
            tick();
            check("R7 beat", beat_idx, k % 4);
            check(m ? "R11 R9 linear addr" : "R10 R9 xor addr", addr_out,
                  {st[16:2], exp_lo(st[1:0], 2'(k), m[0])});
            if (k == 4) check("R13 wrap", addr_out, st);
          end
        end
      end
    end

    // R12: mode change takes effect without a clock
    idle(); mode_linear = 0; addr_in = 17'h00401; ctrl_strobe_n = 0; tick();
    idle(); step_n = 0; tick(); step_n = 1;
    check("R12 xor before", addr_out[1:0], 0);
    mode_linear = 1; #1;
    check("R12 linear now", addr_out[1:0], 2);

    // R8: suspend holds
    tick(); tick();
    check("R8 hold beat", beat_idx, 1); check("R8 hold addr", addr_out, 17'h00402);

    // R5: processor strobe ignored when primary enable inactive
    idle(); proc_strobe_n = 0; sel_lo_n = 1; addr_in = 17'h1F0F3; tick(); idle();
    check("R5 addr", addr_out, 17'h00402); check("R5 beat", beat_idx, 1);
    check("R5 src", src_proc, 0); check("R5 sel", burst_sel, 1);

    // R4: both accepted -> processor wins
    idle(); proc_strobe_n = 0; ctrl_strobe_n = 0; addr_in = 17'h0AAA8; tick(); idle();
    check("R4 src", src_proc, 1); check("R4 addr", addr_out, 17'h0AAA8);

    // R3: controller loads while processor strobe is blocked
    idle(); proc_strobe_n = 0; ctrl_strobe_n = 0; sel_lo_n = 1; addr_in = 17'h15557; tick(); idle();
    check("R3 src blocked proc", src_proc, 0); check("R3 addr", addr_out, 17'h15557);
    check("R6 sel lo off", burst_sel, 0);
    step_n = 0; tick(); step_n = 1;
    check("R8 deselected no step", beat_idx, 0);

    // R6: other enables
    idle(); ctrl_strobe_n = 0; sel_hi = 0; addr_in = 17'h00010; tick(); idle();
    check("R6 sel hi off", burst_sel, 0);
    idle(); ctrl_strobe_n = 0; sel_exp_n = 1; tick(); idle();
    check("R6 sel exp off", burst_sel, 0);
    idle(); ctrl_strobe_n = 0; tick(); idle();
    check("R6 sel on", burst_sel, 1);

    // R1 again: reset mid-burst
    step_n = 0; tick(); rst_n = 0; tick();
    check("R1 rst beat", beat_idx, 0); check("R1 rst addr", addr_out, 0);
    check("R1 rst sel", burst_sel, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule